// File: doc/BRIEF.md
# Urgency-Priority Output Arbiter with Discard

This block settles contention for the outputs of a three-port router that moves one-phit messages along precomputed routes. Each input buffer presents its head message as a request made of a valid bit, the index of the output it wants, a 5-bit count of the cycles left before the message is needed, and a flag that marks the message as expendable. For every output, the block picks the requester with the least time to spare and grants it. The losers of a collision are handled according to their flag. An expendable loser is told to discard its message. Any other loser keeps its message and competes again in the next cycle. A message whose count has reached zero is too late to be of use, so it is always discarded and never forwarded.

The block is purely combinational from request to strobe, so a buffer can pop on a grant or a drop in the same cycle it presents its head. The clock and reset inputs only time the embedded checks. Buffer storage, route computation and the crossbar are outside the block. The crossbar takes its selection from the grant vector together with the route of each granted input.

Top module: `urgency_arbiter`

## Requirements
- R1: At most one input is granted per output in a cycle. Inputs routed to different outputs may be granted in the same cycle.
- R2: Among live requests (valid, urgency not zero) that share an output, the grant goes to the one with the smallest urgency value.
- R3: When the smallest urgency value is shared by several live requests on one output, the lowest input index wins.
- R4: A live request that loses its collision and has its expendable bit set receives a drop strobe in that cycle.
- R5: A live request that loses its collision and has its expendable bit clear receives neither a grant nor a drop. When the winner is gone, it is granted in a later cycle.
- R6: A valid request with urgency value 0 receives a drop strobe and no grant, even when it is alone on its output or its expendable bit is clear.
- R7: No input receives a grant and a drop strobe in the same cycle.
- R8: An input whose valid bit is low receives neither a grant nor a drop, whatever its other fields hold.
- R9: A live request that is alone on its output is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that samples the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset, disables the checks |
| req_i | input | 3 | Per-input head-of-buffer valid, bit i for input i |
| route_i | input | 6 | Wanted output index, 2 bits per input, input i at bits [2i+1:2i] |
| urg_i | input | 15 | Remaining urgency, 5 bits per input, input i at bits [5i+4:5i] |
| exp_i | input | 3 | Expendable flag per input, 1 means the message may be discarded |
| grant_o | output | 3 | Per-input grant strobe, the head message is forwarded this cycle |
| drop_o | output | 3 | Per-input drop strobe, the head message is discarded this cycle |

## Verification
The checks assume that every valid request names an existing output, so that route values stay below 3. With a route outside that range, a live request would never be granted, and the checks tying loss to a drop or a hold would fail. The directed stimulus only ever routes to outputs 0 to 2. It changes inputs on the falling edge, so the combinational strobes are settled before the rising edge at which the checks sample them. Fields of inputs whose valid bit is low are sometimes filled with values that would otherwise trigger a drop, to show they are ignored.

// File: rtl/urg_arb_pkg.sv
package urg_arb_pkg;
  localparam int unsigned DEF_PORTS = 3;
  localparam int unsigned DEF_URG_W = 5;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/urg_req_decode.sv
module urg_req_decode #(
  parameter int unsigned NUM_PORTS = urg_arb_pkg::DEF_PORTS,
  parameter int unsigned URG_W     = urg_arb_pkg::DEF_URG_W,
  localparam int unsigned RTE_W    = urg_arb_pkg::idx_w(NUM_PORTS)
) (
  input  logic [NUM_PORTS-1:0]                      req_i,
  input  logic [NUM_PORTS*RTE_W-1:0]                route_i,
  input  logic [NUM_PORTS*URG_W-1:0]                urg_i,
  output logic [NUM_PORTS-1:0][NUM_PORTS-1:0]       want_o,
  output logic [NUM_PORTS-1:0]                      live_o,
  output logic [NUM_PORTS-1:0]                      expired_o
);
  always_comb begin
    want_o = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      expired_o[i] = req_i[i] && (urg_i[i*URG_W +: URG_W] == '0);
      live_o[i]    = req_i[i] && (urg_i[i*URG_W +: URG_W] != '0);
      for (int o = 0; o < NUM_PORTS; o++) begin
        if (live_o[i] && (route_i[i*RTE_W +: RTE_W] == RTE_W'(o)))
          want_o[o][i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/urg_min_select.sv
module urg_min_select #(
  parameter int unsigned NUM_PORTS = urg_arb_pkg::DEF_PORTS,
  parameter int unsigned URG_W     = urg_arb_pkg::DEF_URG_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PORTS-1:0]       mask_i,
  input  logic [NUM_PORTS*URG_W-1:0] urg_i,
  output logic [NUM_PORTS-1:0]       gnt_o
);
  logic             found;
  logic [URG_W-1:0] best_urg;

  // strict less-than keeps the lowest index on ties
  always_comb begin
    found    = 1'b0;
    best_urg = '1;
    gnt_o    = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (mask_i[i] && (!found || urg_i[i*URG_W +: URG_W] < best_urg)) begin
        found    = 1'b1;
        best_urg = urg_i[i*URG_W +: URG_W];
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R1
  AST_GRANT_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~mask_i) == '0); // R8
  AST_GRANT_IF_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mask_i) |-> (|gnt_o)); // R9

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_win
    for (genvar gj = 0; gj < NUM_PORTS; gj++) begin : g_rival
      if (gi != gj) begin : g_pair
        AST_MIN_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
          gnt_o[gi] && mask_i[gj] |->
            urg_i[gi*URG_W +: URG_W] <= urg_i[gj*URG_W +: URG_W]); // R2
      end
      if (gj < gi) begin : g_low
        AST_TIE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
          gnt_o[gi] && mask_i[gj] |->
            urg_i[gj*URG_W +: URG_W] != urg_i[gi*URG_W +: URG_W]); // R3
      end
    end
  end
endmodule

// File: rtl/urgency_arbiter.sv
module urgency_arbiter #(
  parameter int unsigned NUM_PORTS = urg_arb_pkg::DEF_PORTS,
  parameter int unsigned URG_W     = urg_arb_pkg::DEF_URG_W,
  localparam int unsigned RTE_W    = urg_arb_pkg::idx_w(NUM_PORTS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PORTS-1:0]       req_i,
  input  logic [NUM_PORTS*RTE_W-1:0] route_i,
  input  logic [NUM_PORTS*URG_W-1:0] urg_i,
  input  logic [NUM_PORTS-1:0]       exp_i,
  output logic [NUM_PORTS-1:0]       grant_o,
  output logic [NUM_PORTS-1:0]       drop_o
);
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] want;
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] gnt_by_out;
  logic [NUM_PORTS-1:0]                live;
  logic [NUM_PORTS-1:0]                expired;

  urg_req_decode #(.NUM_PORTS(NUM_PORTS), .URG_W(URG_W)) i_decode (
    .req_i     (req_i),
    .route_i   (route_i),
    .urg_i     (urg_i),
    .want_o    (want),
    .live_o    (live),
    .expired_o (expired)
  );

  for (genvar go = 0; go < NUM_PORTS; go++) begin : g_out
    urg_min_select #(.NUM_PORTS(NUM_PORTS), .URG_W(URG_W)) i_select (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mask_i (want[go]),
      .urg_i  (urg_i),
      .gnt_o  (gnt_by_out[go])
    );
  end

  always_comb begin
    grant_o = '0;
    for (int o = 0; o < NUM_PORTS; o++) grant_o |= gnt_by_out[o];
  end

  // every live request on a valid route either wins or loses a collision
  assign drop_o = expired | (live & ~grant_o & exp_i);

  AST_NO_GNT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & drop_o) == '0); // R7

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_chk
    AST_EXPIRED_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[gi] && urg_i[gi*URG_W +: URG_W] == '0 |->
        drop_o[gi] && !grant_o[gi]); // R6
    AST_EXP_LOSER_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[gi] && urg_i[gi*URG_W +: URG_W] != '0 && exp_i[gi] && !grant_o[gi] |->
        drop_o[gi]); // R4
    AST_KEEP_WAITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[gi] && urg_i[gi*URG_W +: URG_W] != '0 && !exp_i[gi] && !grant_o[gi] |->
        !drop_o[gi]); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i[gi] |-> !grant_o[gi] && !drop_o[gi]); // R8
  end
endmodule

// File: tb/test_urgency_arbiter.sv
module test_urgency_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  req = '0;
  logic [5:0]  route = '0;
  logic [14:0] urg = '0;
  logic [2:0]  expf = '0;
  logic [2:0]  grant;
  logic [2:0]  drop;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  urgency_arbiter i_urgency_arbiter (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .route_i (route),
    .urg_i (urg), .exp_i (expf), .grant_o (grant), .drop_o (drop)
  );

  task automatic drive(input logic [2:0] r, input logic [1:0] rt2, rt1, rt0,
                       input logic [4:0] u2, u1, u0, input logic [2:0] e);
    @(negedge clk);
    req = r; route = {rt2, rt1, rt0}; urg = {u2, u1, u0}; expf = e;
    #1;
  endtask

  task automatic check(input string tag, input logic [2:0] eg, ed);
    checks += 2;
    if (grant !== eg) begin
      errors++;
      $display("FAIL %s grant actual=%b expected=%b", tag, grant, eg);
    end
    if (drop !== ed) begin
      errors++;
      $display("FAIL %s drop actual=%b expected=%b", tag, drop, ed);
    end
  endtask

  task automatic t_idle();
    drive(3'b000, 2'd0, 2'd0, 2'd0, 5'd0, 5'd0, 5'd0, 3'b111);
    check("R8 idle with zero urgency fields", 3'b000, 3'b000);
  endtask

  task automatic t_single();
    drive(3'b001, 2'd0, 2'd0, 2'd1, 5'd0, 5'd0, 5'd7, 3'b000);
    check("R9 lone request", 3'b001, 3'b000);
  endtask

  task automatic t_collide_exp();
    drive(3'b111, 2'd0, 2'd0, 2'd0, 5'd12, 5'd4, 5'd9, 3'b101);
    check("R2 R4 min wins, expendable losers dropped", 3'b010, 3'b101);
  endtask

  task automatic t_collide_keep();
    drive(3'b111, 2'd0, 2'd0, 2'd0, 5'd12, 5'd4, 5'd9, 3'b000);
    check("R5 non-expendable losers held", 3'b010, 3'b000);
    drive(3'b101, 2'd0, 2'd0, 2'd0, 5'd12, 5'd4, 5'd9, 3'b000);
    check("R5 held loser wins after winner leaves", 3'b001, 3'b000);
  endtask

  task automatic t_tie();
    drive(3'b111, 2'd2, 2'd2, 2'd2, 5'd3, 5'd3, 5'd6, 3'b101);
    check("R3 tie to lowest index", 3'b010, 3'b101);
  endtask

  task automatic t_expired();
    drive(3'b001, 2'd0, 2'd0, 2'd0, 5'd0, 5'd0, 5'd0, 3'b000);
    check("R6 lone expired dropped", 3'b000, 3'b001);
    drive(3'b011, 2'd0, 2'd0, 2'd0, 5'd0, 5'd2, 5'd0, 3'b000);
    check("R6 expired loses to live", 3'b010, 3'b001);
  endtask

  task automatic t_parallel();
    drive(3'b111, 2'd1, 2'd0, 2'd2, 5'd30, 5'd1, 5'd5, 3'b111);
    check("R1 R7 distinct outputs all granted", 3'b111, 3'b000);
  endtask

  task automatic t_mixed();
    drive(3'b111, 2'd1, 2'd0, 2'd1, 5'd8, 5'd8, 5'd8, 3'b111);
    check("R1 R3 one per output", 3'b011, 3'b100);
  endtask

  task automatic t_extremes();
    drive(3'b101, 2'd0, 2'd0, 2'd0, 5'd30, 5'd0, 5'd31, 3'b011);
    check("R2 R8 31 vs 30, idle input ignored", 3'b100, 3'b001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset no requests", 3'b000, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    t_idle();
    t_single();
    t_collide_exp();
    t_collide_keep();
    t_tie();
    t_expired();
    t_parallel();
    t_mixed();
    t_extremes();
    @(negedge clk);
    req = '0;
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule